// File: doc/BRIEF.md
# Strip Buffer Fill Monitor

This block watches how full a raster-to-block strip buffer is and raises two flags for the logic around it. The buffer's storage and its pixel reordering sit elsewhere. The monitor only sees the occupancy count, the capacity, the read and write strobes, the transfer direction, an idle indication and the field timing.

When data is being compressed, the buffer fills from the raster side. Here the busy flag warns that the buffer is close to overflowing. When data is being decompressed, the buffer drains toward the display. Here the busy flag warns that too few blocks remain to produce the next video line.

A write into a full buffer, or a read from an empty one, is a data corruption event. It raises a sticky error flag. If the corruption happens while the buffer is near its limit, the busy flag is also held. Both flags are then released only when the next field begins. The next field is signalled by the active-low end-of-field input going high again.

Top module: `strip_fill_monitor`

## Requirements
- R1: With `comp_mode`=1 and `idle`=0, `busy_o` is 1 when the free space is 16 or less. Free space is `cap - occ`, taken as 0 when `occ` is at or above `cap`. With more than 16 free, `busy_o` is 0 unless R6 holds it.
- R2: With `comp_mode`=0 and `idle`=0, `busy_o` is 1 when `occ` is below `line_thr`. `line_thr` is the number of entries needed to output one line. `busy_o` is 0 when `occ` is at or above `line_thr`, unless R6 holds it.
- R3: While `idle`=1, `busy_o` is 0 one cycle later, and strobes raise no error.
- R4: In compression, `wr_stb`=1 with `occ` at or above `cap` sets `err_o`. In decompression, `rd_stb`=1 with `occ`=0 sets `err_o`. A read in compression never sets it, and a write in decompression never sets it.
- R5: `err_o` stays 1 until the next field start, which clears it. A field start is a clock where `fld_end_n` is 1 and was 0 on the previous clock. A corruption event in the same cycle as a field start leaves `err_o` at 1.
- R6: A corruption event that happens while the R1/R2 near-limit condition is true holds `busy_o` at 1 until the next field start, whatever the occupancy does. This hold is overridden by R3.
- R7: When no hold is active, `busy_o` returns to 0 one cycle after the near-limit condition ends.
- R8: While `rst` is 1, and after it on the first sampled cycle, `busy_o` is 1 and `err_o` is 0.
- R9: Both outputs are registered. The inputs seen at a rising clock edge determine the outputs just after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| comp_mode | input | 1 | 1 = compression, 0 = decompression |
| idle | input | 1 | Block is idle; suppresses busy and error detection |
| occ | input | OCC_W | Current buffer occupancy |
| cap | input | OCC_W | Buffer capacity |
| line_thr | input | OCC_W | Occupancy needed to output one line |
| wr_stb | input | 1 | Write into the buffer this cycle |
| rd_stb | input | 1 | Read from the buffer this cycle |
| fld_end_n | input | 1 | End-of-field, active low; a rising edge starts a field |
| busy_o | output | 1 | Near-limit warning |
| err_o | output | 1 | Sticky corruption flag |

## Verification
The assertions check the following on every cycle:
- an idle cycle forces busy low;
- every corruption event sets the error flag;
- the error flag only drops at a field start;
- a held busy cannot fall before that start;
- a field start cannot repeat on consecutive clocks.

Some behaviour can only be shown by the bench's scenarios:
- the exact threshold arithmetic at 16 free entries and at the line threshold;
- the clamp when occupancy exceeds capacity;
- which strobe counts as a fault in each mode;
- the release of busy after a hold.

The bench covers these with directed edge values, plus random occupancy placed close to both limits.

// File: rtl/strip_mon_pkg.sv
package strip_mon_pkg;
  typedef enum logic {
    XFER_DECOMP = 1'b0,
    XFER_COMP   = 1'b1
  } xfer_mode_e;

  function automatic logic [15:0] free_entries(input logic [15:0] cap_v, input logic [15:0] occ_v);
    return (cap_v > occ_v) ? (cap_v - occ_v) : 16'd0;
  endfunction
endpackage

// File: rtl/smon_field_edge.sv
module smon_field_edge (
  input  logic clk,
  input  logic rst,
  input  logic fld_end_n,
  output logic fld_start
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= fld_end_n;
  end

  assign fld_start = fld_end_n & ~prev_q;

  // R5: a field start is a single-cycle event
  p_start_once_r5: assert property (@(posedge clk) disable iff (rst)
    fld_start |=> !fld_start);
endmodule

// File: rtl/smon_level_cmp.sv
module smon_level_cmp
  import strip_mon_pkg::*;
#(
  parameter int OCC_W  = 12,
  parameter int MARGIN = 16
) (
  input  xfer_mode_e       mode,
  input  logic             idle,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] cap,
  input  logic [OCC_W-1:0] line_thr,
  output logic             near
);
  localparam logic [15:0] MARGIN_V = 16'(MARGIN);
  logic [15:0] free_v;
  logic        near_full;
  logic        near_empty;

  always_comb begin
    free_v     = free_entries(16'(cap), 16'(occ));
    near_full  = (free_v <= MARGIN_V);
    near_empty = (occ < line_thr);
    near       = 1'b0;
    if (!idle) near = (mode == XFER_COMP) ? near_full : near_empty;
  end
endmodule

// File: rtl/smon_fault_det.sv
module smon_fault_det
  import strip_mon_pkg::*;
#(
  parameter int OCC_W = 12
) (
  input  xfer_mode_e       mode,
  input  logic             idle,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] cap,
  input  logic             wr_stb,
  input  logic             rd_stb,
  output logic             fault
);
  logic over_f;
  logic under_f;

  always_comb begin
    over_f  = wr_stb && (occ >= cap);
    under_f = rd_stb && (occ == '0);
    fault   = 1'b0;
    if (!idle) fault = (mode == XFER_COMP) ? over_f : under_f;
  end
endmodule

// File: rtl/strip_fill_monitor.sv
module strip_fill_monitor
  import strip_mon_pkg::*;
#(
  parameter int OCC_W  = 12,
  parameter int MARGIN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             comp_mode,
  input  logic             idle,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] cap,
  input  logic [OCC_W-1:0] line_thr,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             fld_end_n,
  output logic             busy_o,
  output logic             err_o
);
  xfer_mode_e mode;
  logic near, fault, fld_start;
  logic lock_q, lock_n, err_n, busy_n;

  assign mode = xfer_mode_e'(comp_mode);

  smon_field_edge u_edge (
    .clk(clk), .rst(rst), .fld_end_n(fld_end_n), .fld_start(fld_start)
  );

  smon_level_cmp #(.OCC_W(OCC_W), .MARGIN(MARGIN)) u_level (
    .mode(mode), .idle(idle), .occ(occ), .cap(cap), .line_thr(line_thr), .near(near)
  );

  smon_fault_det #(.OCC_W(OCC_W)) u_fault (
    .mode(mode), .idle(idle), .occ(occ), .cap(cap),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .fault(fault)
  );

  always_comb begin
    lock_n = (fault && near) || (lock_q && !fld_start);
    err_n  = fault || (err_o && !fld_start);
    busy_n = !idle && (near || lock_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      err_o  <= 1'b0;
      busy_o <= 1'b1;
    end else begin
      lock_q <= lock_n;
      err_o  <= err_n;
      busy_o <= busy_n;
    end
  end

  // R3: idle forces busy low on the next cycle
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    idle |=> !busy_o);
  // R4: a corruption event sets the error flag
  p_err_set_r4: assert property (@(posedge clk) disable iff (rst)
    fault |=> err_o);
  // R5: the error flag only drops at a field start
  p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (err_o && !fld_start) |=> err_o);
  // R6: a held busy persists until the field start unless idle
  p_lock_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !fld_start && !idle) |=> busy_o);
endmodule

// File: tb/strip_fill_monitor_tb.sv
module strip_fill_monitor_tb;
  localparam int W = 12;
  logic clk = 1'b0;
  logic rst, comp_mode, idle, wr_stb, rd_stb, fld_end_n;
  logic [W-1:0] occ, cap, line_thr;
  logic busy_o, err_o;
  int n_chk = 0, n_fail = 0;
  logic m_busy, m_err, m_lock, m_prev;

  always #4 clk = ~clk;

  strip_fill_monitor #(.OCC_W(W), .MARGIN(16)) u_dut (
    .clk(clk), .rst(rst), .comp_mode(comp_mode), .idle(idle), .occ(occ), .cap(cap),
    .line_thr(line_thr), .wr_stb(wr_stb), .rd_stb(rd_stb), .fld_end_n(fld_end_n),
    .busy_o(busy_o), .err_o(err_o)
  );

  function automatic logic f_near(logic c, logic i, logic [W-1:0] o, logic [W-1:0] k, logic [W-1:0] t);
    logic [W-1:0] fr;
    fr = (k > o) ? k - o : '0;
    if (i) return 1'b0;
    return c ? (fr <= 16) : (o < t);
  endfunction

  function automatic logic f_fault(logic c, logic i, logic [W-1:0] o, logic [W-1:0] k, logic w, logic r);
    if (i) return 1'b0;
    return c ? (w && o >= k) : (r && o == '0);
  endfunction

  task automatic step(string tag);
    logic nr, ft, fs;
    if (rst) begin
      m_busy = 1; m_err = 0; m_lock = 0; m_prev = 1;
    end else begin
      nr = f_near(comp_mode, idle, occ, cap, line_thr);
      ft = f_fault(comp_mode, idle, occ, cap, wr_stb, rd_stb);
      fs = fld_end_n && !m_prev;
      m_lock = (ft && nr) || (m_lock && !fs);
      m_err  = ft || (m_err && !fs);
      m_busy = !idle && (nr || m_lock);
      m_prev = fld_end_n;
    end
    @(posedge clk); #2;
    n_chk++;
    if (busy_o !== m_busy || err_o !== m_err) begin
      n_fail++;
      $display("FAIL %s: busy=%b err=%b expected busy=%b err=%b", tag, busy_o, err_o, m_busy, m_err);
    end
  endtask

  task automatic setin(logic c, logic i, int o, int k, int t, logic w, logic r, logic f);
    comp_mode = c; idle = i; occ = W'(o); cap = W'(k); line_thr = W'(t);
    wr_stb = w; rd_stb = r; fld_end_n = f;
  endtask

  task automatic new_field();
    setin(comp_mode, 0, 500, 1000, 20, 0, 0, 0); step("R5");
    fld_end_n = 1; step("R5");
  endtask

  initial begin
    #1600000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    rst = 1; setin(1, 0, 0, 1000, 20, 0, 0, 1);
    step("R8"); step("R8");
    rst = 0;
    // R1: threshold at 16 free entries, and the clamp when occ exceeds cap
    setin(1, 0, 984, 1000, 20, 0, 0, 1); step("R1");
    setin(1, 0, 983, 1000, 20, 0, 0, 1); step("R1");
    setin(1, 0, 1100, 1000, 20, 0, 0, 1); step("R1");
    // R7: busy drops one cycle after the near condition ends
    setin(1, 0, 500, 1000, 20, 0, 0, 1); step("R7");
    // R2: line threshold in decompression
    setin(0, 0, 19, 1000, 20, 0, 0, 1); step("R2");
    setin(0, 0, 20, 1000, 20, 0, 0, 1); step("R2");
    // R3: idle suppresses busy and faults
    setin(1, 1, 1000, 1000, 20, 1, 0, 1); step("R3");
    // R4: a read in compression and a write in decompression are not faults
    setin(1, 0, 0, 1000, 20, 0, 1, 1); step("R4");
    setin(0, 0, 0, 1000, 20, 1, 0, 1); step("R4");
    // R4: overflow in compression; R6: busy then held
    setin(1, 0, 1000, 1000, 20, 1, 0, 1); step("R4");
    setin(1, 0, 300, 1000, 20, 0, 0, 1); step("R6");
    step("R5"); step("R6");
    new_field();
    setin(1, 0, 300, 1000, 20, 0, 0, 1); step("R5");
    // R4: underflow in decompression
    setin(0, 0, 0, 1000, 20, 0, 1, 1); step("R4");
    setin(0, 0, 400, 1000, 20, 0, 0, 1); step("R6");
    // R5: a fault in the same cycle as the field start keeps err set
    setin(0, 0, 400, 1000, 20, 0, 0, 0); step("R5");
    setin(0, 0, 0, 1000, 20, 0, 1, 1); step("R5");
    new_field();
    // R9: random traffic around both limits, checked every cycle
    for (int n = 0; n < 3000; n++) begin
      logic c;
      int k, o;
      c = 1'($urandom);
      k = 900 + int'($urandom % 100);
      o = (c) ? k - 24 + int'($urandom % 30) : int'($urandom % 40);
      if (o < 0) o = 0;
      setin(c, ($urandom % 16) == 0, o, k, 10 + int'($urandom % 20),
            ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 50) != 0);
      rst = ($urandom % 400) == 0;
      step("R9");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule